// File: doc/BRIEF.md
# Dual-Operand Effective Address Generator

This block forms the memory addresses for both sides of a register-to-memory or memory-to-memory move. Each operand carries its own 4-bit addressing-mode code and pointer register number. The two operands share one offset-register index and one sign-extended literal. The block sends the three register indices out to a 16-entry working register file and gets the contents back through combinational read ports. From those it computes each operand's effective address and the updated pointer value for the modes that step a pointer.

A one-cycle `start` pulse captures the request. On the next cycle, `out_valid` is high for one cycle and presents the source address, the destination address and the two pointer write-back ports. When both operands modify the same pointer, only the destination write-back is issued. All address arithmetic is `DW` bits wide and wraps around.

Mode codes: 0 register direct, 1 file direct (the address is `file_addr`, passed through unchanged), 2 indirect, 3 post-increment, 4 post-decrement, 5 pre-increment, 6 pre-decrement, 7 indexed (pointer plus offset register), 8 literal offset (pointer plus sign-extended literal). Codes 9 to 15 behave as register direct.

Top module: `ea_dual_gen`

## Requirements
- R1: `out_valid` is high exactly in the cycle after each cycle in which `start` was high. Both write enables are low whenever `out_valid` is low.
- R2: Register-direct mode (code 0), and any code from 9 to 15, gives `*_mem`=0, an address of 0 and no write-back.
- R3: File-direct mode (code 1) gives `*_mem`=1 and an address equal to `file_addr`, with no write-back.
- R4: Indirect mode (code 2) gives the pointer register's contents as the address and no write-back.
- R5: Post-increment (3) and post-decrement (4) give the original pointer value as the address. They write back the pointer plus or minus the step, with the write index set to the pointer register.
- R6: Pre-increment (5) and pre-decrement (6) give the pointer plus or minus the step as the address. They write back that same value.
- R7: The step is 1 when `byte_op`=1 and 2 when `byte_op`=0.
- R8: Indexed mode (7) gives the pointer plus the register named by `off_reg` as the address.
- R9: Literal-offset mode (8) gives the pointer plus `lit`, sign-extended from `LIT_W` bits, as the address.
- R10: All sums and differences wrap modulo 2^DW.
- R11: The source and the destination decode their modes independently within one request.
- R12: When both operands modify the same pointer register, only the destination write port (`wb1`) is enabled, and it carries the destination's value.
- R13: While `rst_n` is low, `out_valid`, `wb0_en` and `wb1_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture the current request |
| byte_op | input | 1 | 1 = byte step, 0 = word step |
| src_mode | input | 4 | Source addressing mode |
| src_reg | input | 4 | Source pointer register |
| dst_mode | input | 4 | Destination addressing mode |
| dst_reg | input | 4 | Destination pointer register |
| off_reg | input | 4 | Shared offset register index |
| lit | input | LIT_W | Shared signed literal offset |
| file_addr | input | DW | Explicit address for file-direct mode |
| rd_src_idx | output | 4 | Register file read index, source pointer |
| rd_src_data | input | DW | Register file read data, source pointer |
| rd_dst_idx | output | 4 | Register file read index, destination pointer |
| rd_dst_data | input | DW | Register file read data, destination pointer |
| rd_off_idx | output | 4 | Register file read index, offset register |
| rd_off_data | input | DW | Register file read data, offset register |
| out_valid | output | 1 | Results valid this cycle |
| src_mem | output | 1 | Source is a memory operand |
| src_ea | output | DW | Source effective address |
| dst_mem | output | 1 | Destination is a memory operand |
| dst_ea | output | DW | Destination effective address |
| wb0_en | output | 1 | Source pointer write-back enable |
| wb0_idx | output | 4 | Source write-back register |
| wb0_data | output | DW | Source write-back value |
| wb1_en | output | 1 | Destination pointer write-back enable |
| wb1_idx | output | 4 | Destination write-back register |
| wb1_data | output | DW | Destination write-back value |

## Verification
On every cycle, the assertions check the handshake timing, that write-backs stay gated by `out_valid`, and that a write-back only ever comes from a memory operand. They also check that the two write ports never target the same register together and that captured addresses hold steady between requests. The actual address values cannot be shown by a property and come only from the bench's scenarios. These cover each mode's arithmetic, the byte and word steps, literal sign extension, wraparound at both ends of the address space, mixed source and destination modes, and the same-pointer collision.

// File: rtl/ea_dual_gen.sv
module ea_dual_gen #(
  parameter int DW    = 16,
  parameter int LIT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             byte_op,
  input  logic [3:0]       src_mode,
  input  logic [3:0]       src_reg,
  input  logic [3:0]       dst_mode,
  input  logic [3:0]       dst_reg,
  input  logic [3:0]       off_reg,
  input  logic [LIT_W-1:0] lit,
  input  logic [DW-1:0]    file_addr,
  output logic [3:0]       rd_src_idx,
  input  logic [DW-1:0]    rd_src_data,
  output logic [3:0]       rd_dst_idx,
  input  logic [DW-1:0]    rd_dst_data,
  output logic [3:0]       rd_off_idx,
  input  logic [DW-1:0]    rd_off_data,
  output logic             out_valid,
  output logic             src_mem,
  output logic [DW-1:0]    src_ea,
  output logic             dst_mem,
  output logic [DW-1:0]    dst_ea,
  output logic             wb0_en,
  output logic [3:0]       wb0_idx,
  output logic [DW-1:0]    wb0_data,
  output logic             wb1_en,
  output logic [3:0]       wb1_idx,
  output logic [DW-1:0]    wb1_data
);
  localparam int RW = 2 * DW + 2;

  localparam logic [3:0] M_REG  = 4'd0;
  localparam logic [3:0] M_FILE = 4'd1;
  localparam logic [3:0] M_IND  = 4'd2;
  localparam logic [3:0] M_PSTI = 4'd3;
  localparam logic [3:0] M_PSTD = 4'd4;
  localparam logic [3:0] M_PREI = 4'd5;
  localparam logic [3:0] M_PRED = 4'd6;
  localparam logic [3:0] M_IDX  = 4'd7;
  localparam logic [3:0] M_LIT  = 4'd8;

  assign rd_src_idx = src_reg;
  assign rd_dst_idx = dst_reg;
  assign rd_off_idx = off_reg;

  wire [DW-1:0] step  = byte_op ? DW'(1) : DW'(2);
  wire [DW-1:0] lit_x = {{(DW-LIT_W){lit[LIT_W-1]}}, lit};

  // result layout: {mem, modify, ea, new pointer}
  function automatic logic [RW-1:0] calc(input logic [3:0] m, input logic [DW-1:0] wn,
                                         input logic [DW-1:0] wo, input logic [DW-1:0] lx,
                                         input logic [DW-1:0] fa, input logic [DW-1:0] st);
    logic [DW-1:0] up, dn;
    up = wn + st;
    dn = wn - st;
    case (m)
      M_FILE: calc = {1'b1, 1'b0, fa,      wn};
      M_IND:  calc = {1'b1, 1'b0, wn,      wn};
      M_PSTI: calc = {1'b1, 1'b1, wn,      up};
      M_PSTD: calc = {1'b1, 1'b1, wn,      dn};
      M_PREI: calc = {1'b1, 1'b1, up,      up};
      M_PRED: calc = {1'b1, 1'b1, dn,      dn};
      M_IDX:  calc = {1'b1, 1'b0, wn + wo, wn};
      M_LIT:  calc = {1'b1, 1'b0, wn + lx, wn};
      default: calc = {1'b0, 1'b0, {DW{1'b0}}, wn};
    endcase
  endfunction

  wire [RW-1:0] s_res = calc(src_mode, rd_src_data, rd_off_data, lit_x, file_addr, step);
  wire [RW-1:0] d_res = calc(dst_mode, rd_dst_data, rd_off_data, lit_x, file_addr, step);

  wire s_mod   = s_res[RW-2];
  wire d_mod   = d_res[RW-2];
  wire clash   = s_mod && d_mod && (src_reg == dst_reg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wb0_en    <= 1'b0;
      wb1_en    <= 1'b0;
      src_mem   <= 1'b0;
      dst_mem   <= 1'b0;
      src_ea    <= '0;
      dst_ea    <= '0;
      wb0_idx   <= '0;
      wb1_idx   <= '0;
      wb0_data  <= '0;
      wb1_data  <= '0;
    end else begin
      out_valid <= start;
      wb0_en    <= start && s_mod && !clash;
      wb1_en    <= start && d_mod;
      if (start) begin
        src_mem  <= s_res[RW-1];
        dst_mem  <= d_res[RW-1];
        src_ea   <= s_res[2*DW-1:DW];
        dst_ea   <= d_res[2*DW-1:DW];
        wb0_idx  <= src_reg;
        wb1_idx  <= dst_reg;
        wb0_data <= s_res[DW-1:0];
        wb1_data <= d_res[DW-1:0];
      end
    end
  end

  a_r1_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> out_valid);
  a_r1_idle_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !out_valid);
  a_r1_wb_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!wb0_en && !wb1_en));
  a_r5_wb0_from_mem: assert property (@(posedge clk) disable iff (!rst_n)
    wb0_en |-> src_mem);
  a_r6_wb1_from_mem: assert property (@(posedge clk) disable iff (!rst_n)
    wb1_en |-> dst_mem);
  a_r12_no_dual_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wb0_en && wb1_en) |-> (wb0_idx != wb1_idx));
  a_r11_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(src_ea) && $stable(dst_ea)));
endmodule

// File: tb/ea_dual_gen_tb.sv
module ea_dual_gen_tb;
  localparam int DW = 16;
  localparam int LIT_W = 10;
  localparam logic [DW-1:0] FADDR = 16'hABCD;

  typedef struct packed {
    logic [3:0] sm; logic [3:0] sr; logic [3:0] dm; logic [3:0] dr;
    logic [3:0] off; logic [LIT_W-1:0] lit; logic byt;
    logic esm; logic [15:0] esea; logic edm; logic [15:0] edea;
    logic e0; logic [15:0] e0d; logic e1; logic [15:0] e1d;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{4'd2, 4'd2, 4'd2, 4'd3, 4'd0, 10'h000, 1'b0, 1'b1, 16'h2222, 1'b1, 16'h3333, 1'b0, 16'h0, 1'b0, 16'h0},
    '{4'd3, 4'd1, 4'd4, 4'd4, 4'd0, 10'h000, 1'b0, 1'b1, 16'h1111, 1'b1, 16'h4444, 1'b1, 16'h1113, 1'b1, 16'h4442},
    '{4'd5, 4'd5, 4'd6, 4'd6, 4'd0, 10'h000, 1'b1, 1'b1, 16'h5556, 1'b1, 16'h6665, 1'b1, 16'h5556, 1'b1, 16'h6665},
    '{4'd7, 4'd2, 4'd0, 4'd3, 4'd3, 10'h000, 1'b0, 1'b1, 16'h5555, 1'b0, 16'h0000, 1'b0, 16'h0, 1'b0, 16'h0},
    '{4'd8, 4'd7, 4'd1, 4'd0, 4'd0, 10'h3FF, 1'b0, 1'b1, 16'h7776, 1'b1, 16'hABCD, 1'b0, 16'h0, 1'b0, 16'h0},
    '{4'd8, 4'd1, 4'd2, 4'd8, 4'd0, 10'h1FF, 1'b0, 1'b1, 16'h1310, 1'b1, 16'h8888, 1'b0, 16'h0, 1'b0, 16'h0},
    '{4'd3, 4'd15, 4'd7, 4'd15, 4'd2, 10'h000, 1'b0, 1'b1, 16'hFFFF, 1'b1, 16'h2221, 1'b1, 16'h0001, 1'b0, 16'h0},
    '{4'd3, 4'd9, 4'd6, 4'd9, 4'd0, 10'h000, 1'b0, 1'b1, 16'h9999, 1'b1, 16'h9997, 1'b0, 16'h0, 1'b1, 16'h9997},
    '{4'd6, 4'd0, 4'd8, 4'd0, 4'd0, 10'h200, 1'b1, 1'b1, 16'hFFFF, 1'b1, 16'hFE00, 1'b1, 16'hFFFF, 1'b0, 16'h0},
    '{4'd12, 4'd3, 4'd4, 4'd10, 4'd0, 10'h000, 1'b1, 1'b0, 16'h0000, 1'b1, 16'hAAAA, 1'b0, 16'h0, 1'b1, 16'hAAA9},
    '{4'd0, 4'd5, 4'd5, 4'd14, 4'd0, 10'h000, 1'b0, 1'b0, 16'h0000, 1'b1, 16'hEEF0, 1'b0, 16'h0, 1'b1, 16'hEEF0}
  };

  // R-tags per row: 1 R4/R11, 2 R5/R7, 3 R6/R7, 4 R8/R2, 5 R9/R3/R10, 6 R9, 7 R10/R8, 8 R12, 9 R6/R9/R10, 10 R2/R5, 11 R2/R6

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, byte_op = 1'b0;
  logic [3:0] src_mode = '0, src_reg = '0, dst_mode = '0, dst_reg = '0, off_reg = '0;
  logic [LIT_W-1:0] lit = '0;
  logic [3:0] rd_src_idx, rd_dst_idx, rd_off_idx;
  logic [DW-1:0] rd_src_data, rd_dst_data, rd_off_data;
  logic out_valid, src_mem, dst_mem, wb0_en, wb1_en;
  logic [DW-1:0] src_ea, dst_ea, wb0_data, wb1_data;
  logic [3:0] wb0_idx, wb1_idx;
  logic [DW-1:0] regs [16];
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  initial for (int i = 0; i < 16; i++) regs[i] = DW'(i * 16'h1111);

  assign rd_src_data = regs[rd_src_idx];
  assign rd_dst_data = regs[rd_dst_idx];
  assign rd_off_data = regs[rd_off_idx];

  ea_dual_gen #(.DW(DW), .LIT_W(LIT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_op(byte_op),
    .src_mode(src_mode), .src_reg(src_reg), .dst_mode(dst_mode), .dst_reg(dst_reg),
    .off_reg(off_reg), .lit(lit), .file_addr(FADDR),
    .rd_src_idx(rd_src_idx), .rd_src_data(rd_src_data),
    .rd_dst_idx(rd_dst_idx), .rd_dst_data(rd_dst_data),
    .rd_off_idx(rd_off_idx), .rd_off_data(rd_off_data),
    .out_valid(out_valid), .src_mem(src_mem), .src_ea(src_ea),
    .dst_mem(dst_mem), .dst_ea(dst_ea),
    .wb0_en(wb0_en), .wb0_idx(wb0_idx), .wb0_data(wb0_data),
    .wb1_en(wb1_en), .wb1_idx(wb1_idx), .wb1_data(wb1_data));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R13 reset valid", 32'(out_valid), 32'd0);
    check("R13 reset wb", 32'({wb0_en, wb1_en}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle valid", 32'(out_valid), 32'd0);

    for (int k = 0; k < NV; k++) begin
      src_mode = VEC[k].sm; src_reg = VEC[k].sr;
      dst_mode = VEC[k].dm; dst_reg = VEC[k].dr;
      off_reg = VEC[k].off; lit = VEC[k].lit; byte_op = VEC[k].byt;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check($sformatf("R1 row%0d valid", k), 32'(out_valid), 32'd1);
      check($sformatf("R11 row%0d src_mem", k), 32'(src_mem), 32'(VEC[k].esm));
      if (VEC[k].esm) check($sformatf("R4 row%0d src_ea", k), 32'(src_ea), 32'(VEC[k].esea));
      else check($sformatf("R2 row%0d src_ea", k), 32'(src_ea), 32'd0);
      check($sformatf("R11 row%0d dst_mem", k), 32'(dst_mem), 32'(VEC[k].edm));
      check($sformatf("R11 row%0d dst_ea", k), 32'(dst_ea), 32'(VEC[k].edea));
      check($sformatf("R5 row%0d wb0_en", k), 32'(wb0_en), 32'(VEC[k].e0));
      check($sformatf("R12 row%0d wb1_en", k), 32'(wb1_en), 32'(VEC[k].e1));
      if (VEC[k].e0) begin
        check($sformatf("R5 row%0d wb0_idx", k), 32'(wb0_idx), 32'(VEC[k].sr));
        check($sformatf("R7 row%0d wb0_data", k), 32'(wb0_data), 32'(VEC[k].e0d));
      end
      if (VEC[k].e1) begin
        check($sformatf("R6 row%0d wb1_idx", k), 32'(wb1_idx), 32'(VEC[k].dr));
        check($sformatf("R10 row%0d wb1_data", k), 32'(wb1_data), 32'(VEC[k].e1d));
      end
      @(negedge clk);
      check($sformatf("R1 row%0d valid drop", k), 32'(out_valid), 32'd0);
      check($sformatf("R1 row%0d wb gated", k), 32'({wb0_en, wb1_en}), 32'd0);
    end

    // R1: back-to-back starts give two valid cycles
    src_mode = 4'd3; src_reg = 4'd2; dst_mode = 4'd2; dst_reg = 4'd4; byte_op = 1'b1;
    start = 1'b1;
    @(negedge clk);
    check("R1 b2b first", 32'(out_valid), 32'd1);
    check("R7 b2b byte step", 32'(wb0_data), 32'h2223);
    src_reg = 4'd3;
    @(negedge clk);
    start = 1'b0;
    check("R1 b2b second", 32'(out_valid), 32'd1);
    check("R5 b2b src_ea", 32'(src_ea), 32'h3333);
    @(negedge clk);
    check("R1 b2b end", 32'(out_valid), 32'd0);

    // R13: reset mid-flight clears valid
    start = 1'b1;
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0;
    @(negedge clk);
    check("R13 reset clears", 32'({out_valid, wb0_en, wb1_en}), 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule